// File: doc/BRIEF.md
# Register-Content Branch Condition Unit

This block decides whether a conditional branch is taken. It reads one scalar register value and a 4-bit condition code, and it does not use any condition flags. The conditions fall into three groups:

- **Sign tests.** The register is compared with zero as a signed two's-complement number.
- **Word mask tests.** The register is checked against the all-ones pattern that compare-and-set instructions write as "true".
- **Packed-lane tests.** The word is split into byte lanes. The unit reports whether every lane, no lane, or only some lanes hold an all-ones byte.

A request is presented with a valid strobe. The decision appears on a registered output one clock later, together with a registered valid. Any code that is not assigned yields not-taken. Target address generation, flushing and prediction are handled elsewhere in the pipeline.

Top module: `regcond_branch_unit`

## Requirements
- R1: `res_valid` equals `req_valid` from the previous clock. `res_taken` is 0 in every cycle where `res_valid` is 0.
- R2: Code 0 (equal zero) is taken when the value is 0. Code 1 (not zero) is taken when the value is not 0.
- R3: Code 2 (negative) is taken when bit 31 is 1. Code 5 (not negative) is taken when bit 31 is 0.
- R4: Code 3 (zero or negative) is taken when the signed value is at most 0. Code 4 (positive) is taken when the signed value is greater than 0.
- R5: Code 6 (set) is taken only when all 32 bits are 1. Code 7 (not set) is taken for every other value.
- R6: A byte lane is set when all 8 of its bits are 1. The lanes are bits 7:0, 15:8, 23:16 and 31:24. Code 8 (all lanes) is taken when all four lanes are set.
- R7: Code 9 (no lane) is taken when none of the four lanes is set.
- R8: Code 10 (some lanes) is taken when at least one lane is set and at least one lane is not set.
- R9: Codes 11 to 15 are never taken.
- R10: While `rst_n` is low, and until the first strobe after reset release, `res_valid` and `res_taken` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_value | input | 32 | Scalar register contents under test |
| req_cond | input | 4 | Condition code |
| res_valid | output | 1 | Registered request strobe |
| res_taken | output | 1 | Registered branch decision |

## Verification
Every code from 0 to 15 is driven against a fixed set of values: zero, one, minus one, the most negative and most positive words, and lane patterns with zero, one, two, three and four set bytes. Near-miss lanes such as 0xFE are included, so an inverted sign bit, an off-by-one zero boundary, or a lane test that checks only some of its bits gives a different result. A run of random values and codes follows. Idle cycles carry non-zero codes, which checks that a decision never leaks out without a strobe.

// File: rtl/regcond_pkg.sv
package regcond_pkg;
  typedef enum logic [3:0] {
    CC_ZERO   = 4'd0,
    CC_NZERO  = 4'd1,
    CC_NEG    = 4'd2,
    CC_NPOS   = 4'd3,
    CC_POS    = 4'd4,
    CC_NNEG   = 4'd5,
    CC_SET    = 4'd6,
    CC_NSET   = 4'd7,
    CC_LALL   = 4'd8,
    CC_LNONE  = 4'd9,
    CC_LSOME  = 4'd10
  } cond_e;

  localparam int unsigned COND_W = 4;
endpackage

// File: rtl/regcond_sign_eval.sv
module regcond_sign_eval #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] value,
  output logic              is_zero,
  output logic              is_neg,
  output logic              is_pos
);
  always_comb begin
    is_zero = ~|value;
    is_neg  = value[DATA_W-1];
    is_pos  = $signed(value) > $signed({DATA_W{1'b0}});
  end

  // exactly one of zero / negative / positive holds
  always_comb begin
    assert_sign_trichotomy_R4: assert ($onehot({is_zero, is_neg, is_pos}));
  end
endmodule

// File: rtl/regcond_mask_eval.sv
module regcond_mask_eval #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANE_W = 8
) (
  input  logic [DATA_W-1:0] value,
  output logic              word_set,
  output logic              lanes_all,
  output logic              lanes_none,
  output logic              lanes_some
);
  localparam int unsigned LANES = DATA_W / LANE_W;

  logic [LANES-1:0] lane_set;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_set[g] = &value[g*LANE_W +: LANE_W];
  end

  always_comb begin
    word_set   = &value;
    lanes_all  = &lane_set;
    lanes_none = ~|lane_set;
    lanes_some = ~lanes_all & ~lanes_none;
  end

  // a fully set word must show every lane set, and vice versa
  always_comb begin
    assert_word_lane_agree_R6: assert (word_set == lanes_all);
  end
endmodule

// File: rtl/regcond_branch_unit.sv
module regcond_branch_unit
  import regcond_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned LANE_W   = 8,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [DATA_W-1:0] req_value,
  input  logic [COND_W-1:0] req_cond,
  output logic              res_valid,
  output logic              res_taken
);
  // reset: asserted asynchronously, released on a clock edge
  logic [SYNC_LEN-1:0] rst_sync_q;
  logic                rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[SYNC_LEN-1];

  logic is_zero, is_neg, is_pos;
  logic word_set, lanes_all, lanes_none, lanes_some;

  regcond_sign_eval #(.DATA_W(DATA_W)) u_sign (
    .value   (req_value),
    .is_zero (is_zero),
    .is_neg  (is_neg),
    .is_pos  (is_pos)
  );

  regcond_mask_eval #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_mask (
    .value      (req_value),
    .word_set   (word_set),
    .lanes_all  (lanes_all),
    .lanes_none (lanes_none),
    .lanes_some (lanes_some)
  );

  logic decide;
  logic valid_d, taken_d;
  logic valid_q, taken_q;

  always_comb begin
    unique case (req_cond)
      CC_ZERO:  decide = is_zero;
      CC_NZERO: decide = ~is_zero;
      CC_NEG:   decide = is_neg;
      CC_NPOS:  decide = ~is_pos;
      CC_POS:   decide = is_pos;
      CC_NNEG:  decide = ~is_neg;
      CC_SET:   decide = word_set;
      CC_NSET:  decide = ~word_set;
      CC_LALL:  decide = lanes_all;
      CC_LNONE: decide = lanes_none;
      CC_LSOME: decide = lanes_some;
      default:  decide = 1'b0;
    endcase
  end

  // next state
  always_comb begin
    valid_d = req_valid;
    taken_d = req_valid & decide;
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      valid_q <= 1'b0;
      taken_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      taken_q <= taken_d;
    end
  end

  assign res_valid = valid_q;
  assign res_taken = taken_q;

  assert_strobe_follows_R1: assert property (@(posedge clk) disable iff (!rst_s_n)
    req_valid == 1'b1 |=> res_valid);
  assert_idle_follows_R1: assert property (@(posedge clk) disable iff (!rst_s_n)
    req_valid == 1'b0 |=> !res_valid && !res_taken);
  assert_unused_not_taken_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (req_valid && req_cond > 4'd10) |=> !res_taken);
  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rst_s_n |-> !res_valid && !res_taken);
endmodule

// File: tb/regcond_branch_unit_bench.sv
module regcond_branch_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_value;
  logic [3:0]  req_cond;
  logic        res_valid, res_taken;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  regcond_branch_unit u_regcond_branch_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_value(req_value), .req_cond(req_cond),
    .res_valid(res_valid), .res_taken(res_taken)
  );

  function automatic bit ref_take(input logic [31:0] v, input int c);
    int sv = $signed(v);
    int nset = 0;
    for (int b = 0; b < 4; b++) if (v[b*8 +: 8] == 8'hFF) nset++;
    case (c)
      0: return sv == 0;
      1: return sv != 0;
      2: return sv < 0;
      3: return sv <= 0;
      4: return sv > 0;
      5: return sv >= 0;
      6: return v == 32'hFFFF_FFFF;
      7: return v != 32'hFFFF_FFFF;
      8: return nset == 4;
      9: return nset == 0;
      10: return nset > 0 && nset < 4;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input int c);
    case (c)
      0, 1: return "R2";
      2, 5: return "R3";
      3, 4: return "R4";
      6, 7: return "R5";
      8: return "R6";
      9: return "R7";
      10: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // reference state for the cycle after the current drive
  bit    exp_valid, exp_taken;
  string exp_tag;

  // drive at negedge after checking the previous request's result
  task automatic step(input bit v, input logic [31:0] val, input int c);
    check("R1 valid", res_valid, exp_valid);
    check({exp_tag, " taken"}, res_taken, exp_taken);
    req_valid = v;
    req_value = val;
    req_cond  = 4'(c);
    exp_valid = v;
    exp_taken = v && ref_take(val, c);
    exp_tag   = v ? tag_of(c) : "R1";
    @(negedge clk);
  endtask

  logic [31:0] pats [14];

  initial begin
    pats = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF,
             32'hFFFF_FFFE, 32'hFF00_0000, 32'h0000_00FF, 32'hFF00_FF00,
             32'hFFFF_FF00, 32'hFEFE_FEFE, 32'h00FF_00FE, 32'h7FFF_FFFF,
             32'hFFFE_FFFF};
    rst_n = 1'b0; req_valid = 1'b1; req_value = 32'hFFFF_FFFF; req_cond = 4'd6;
    repeat (3) @(negedge clk);
    check("R10 valid in reset", res_valid, 1'b0);
    check("R10 taken in reset", res_taken, 1'b0);
    req_valid = 1'b0;
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check("R10 valid after release", res_valid, 1'b0);
      check("R10 taken after release", res_taken, 1'b0);
    end
    exp_valid = 0; exp_taken = 0; exp_tag = "R1";
    for (int p = 0; p < 14; p++) begin
      for (int c = 0; c < 16; c++) begin
        step(1, pats[p], c);
      end
      step(0, 32'hFFFF_FFFF, 6);   // idle with a would-be-taken code
    end
    for (int i = 0; i < 400; i++) begin
      logic [31:0] rv = $urandom;
      if (i % 3 == 0) rv[15:8] = 8'hFF;
      if (i % 5 == 0) rv[31:24] = 8'hFF;
      step((i % 7) != 0, rv, $urandom_range(0, 15));
    end
    step(0, 32'h0, 0);
    step(0, 32'h0, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule